// File: doc/BRIEF.md
# Recirculating Serial Delay-Line Word Store

This block models a word store built from recirculating serial loops. Thirty-two independent loops each hold sixteen 35-bit words, 512 words in all. Every loop moves one bit per clock. The bit that leaves the far end of a loop is fed straight back into its start, so the contents keep circulating and never need a refresh. Each loop has one access point, the tap. A word can be reached only while its bits pass that tap.

A client raises a request with a loop index, a word slot, a write flag and write data, and the block accepts it while ready is high. The block then waits until the first bit of the addressed word reaches the tap. During the next 35 cycles it either shifts the word into the read register or replaces it bit by bit with the write data. When the last bit has passed, the block pulses done for one cycle and returns to ready. Access latency therefore depends on where the word sits in the circulation. On average the wait is about half of one full circulation, which is 560 cycles.

Top module: `delay_line_mem`

## Requirements
- R1: After reset, ready_o is 1, done_o is 0 and rdata_o is 0, and every word of every loop reads back as 0.
- R2: A request is accepted on a clock edge where req_i and ready_o are both 1. From the next cycle on, ready_o stays 0 until the transfer completes.
- R3: A write replaces the addressed word (line_i, slot_i) with wdata_i, and a later read of that word returns that value.
- R4: A write changes no other word, neither in the same loop nor in any other loop.
- R5: A read leaves the word it reads unchanged, so repeated reads return the same value.
- R6: Stored words are kept unchanged through any number of circulations while no access is made.
- R7: A circulation position starts at 0 in the first cycle after reset and advances by 1 every cycle, modulo 560. Word slot s occupies positions 35*s to 35*s+34, with bit b at position 35*s+b. A transfer starts in the first cycle after acceptance in which the position is 35*s. done_o is 1 in the cycle right after the cycle at position 35*s+34, so ready_o is never 0 for more than 595 cycles.
- R8: done_o is high for exactly one cycle per completed read or write, and ready_o is 1 in that same cycle.
- R9: rdata_o holds its value while the block is ready, and it is changed only by a read.
- R10: req_i while ready_o is 0 has no effect: the request is neither queued nor applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| ready_o | output | 1 | Block idle; a request is accepted this cycle |
| line_i | input | 5 | Loop index of the request |
| slot_i | input | 4 | Word slot within the loop |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 35 | Write data |
| rdata_o | output | 35 | Last word read |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the timing skeleton on every cycle: ready falls after acceptance, done is a single-cycle pulse that coincides with ready, the position counter steps and wraps, done follows the last bit of a word, the busy window stays within one circulation plus one word, and rdata holds while idle. Only the bench's scenarios can show the data behaviour: written words read back, untouched neighbours stay intact, reads leave the store unchanged, data survives many circulations, and requests made while busy are dropped. Its cycle-accurate model also confirms the exact done cycle for each word position.

// File: rtl/delay_line_mem_pkg.sv
package delay_line_mem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_XFER = 2'd2
    } dlm_state_e;
endpackage

// File: rtl/dlm_tap_position.sv
module dlm_tap_position #(
    parameter int WORDS = 16,
    parameter int BITS  = 35,
    localparam int WORD_W = $clog2(WORDS),
    localparam int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] word_o,
    output logic [BIT_W-1:0]  bit_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.bitn == BIT_W'(BITS - 1)) begin
            pos_d.bitn = '0;
            pos_d.word = (pos_q.word == WORD_W'(WORDS - 1)) ? '0 : pos_q.word + 1'b1;
        end else begin
            pos_d.bitn = pos_q.bitn + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign word_o = pos_q.word;
    assign bit_o  = pos_q.bitn;
endmodule

// File: rtl/dlm_recirc_loop.sv
module dlm_recirc_loop #(
    parameter int LOOP_BITS = 560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inj_en,
    input  logic inj_bit,
    output logic tap_o
);
    logic [LOOP_BITS-1:0] loop_d, loop_q;

    // the bit leaving the tap re-enters at the far end unless replaced
    always_comb begin
        loop_d = {inj_en ? inj_bit : loop_q[0], loop_q[LOOP_BITS-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loop_q <= '0;
        else        loop_q <= loop_d;
    end

    assign tap_o = loop_q[0];
endmodule

// File: rtl/delay_line_mem.sv
module delay_line_mem #(
    parameter int NUM_LINES      = 32,
    parameter int WORDS_PER_LINE = 16,
    parameter int WORD_BITS      = 35,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int SLOT_W    = $clog2(WORDS_PER_LINE),
    localparam int BIT_W     = $clog2(WORD_BITS),
    localparam int LOOP_BITS = WORDS_PER_LINE * WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    output logic                 ready_o,
    input  logic [LINE_W-1:0]    line_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic                 we_i,
    input  logic [WORD_BITS-1:0] wdata_i,
    output logic [WORD_BITS-1:0] rdata_o,
    output logic                 done_o
);
    import delay_line_mem_pkg::*;

    typedef struct packed {
        dlm_state_e           state;
        logic [LINE_W-1:0]    line;
        logic [SLOT_W-1:0]    slot;
        logic                 we;
        logic [WORD_BITS-1:0] wdata;
        logic [WORD_BITS-1:0] rdata;
        logic                 done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SLOT_W-1:0]    word_pos;
    logic [BIT_W-1:0]     bit_pos;
    logic [NUM_LINES-1:0] taps;
    logic [NUM_LINES-1:0] inj_en;
    logic                 tap_sel;
    logic                 active;
    logic                 inj_bit;

    // one shared position: every loop shifts in lockstep
    dlm_tap_position #(
        .WORDS (WORDS_PER_LINE),
        .BITS  (WORD_BITS)
    ) pos_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_o (word_pos),
        .bit_o  (bit_pos)
    );

    assign active = (ctl_q.state == ST_XFER) ||
                    (ctl_q.state == ST_SEEK && word_pos == ctl_q.slot && bit_pos == '0);
    assign inj_bit = ctl_q.wdata[bit_pos];
    assign tap_sel = taps[ctl_q.line];

    for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
        assign inj_en[li] = active && ctl_q.we && (ctl_q.line == LINE_W'(li));

        dlm_recirc_loop #(
            .LOOP_BITS (LOOP_BITS)
        ) loop_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .inj_en  (inj_en[li]),
            .inj_bit (inj_bit),
            .tap_o   (taps[li])
        );
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.state = ST_SEEK;
                    ctl_d.line  = line_i;
                    ctl_d.slot  = slot_i;
                    ctl_d.we    = we_i;
                    ctl_d.wdata = wdata_i;
                end
            end
            ST_SEEK, ST_XFER: begin
                if (active) begin
                    if (!ctl_q.we) ctl_d.rdata[bit_pos] = tap_sel;
                    if (bit_pos == BIT_W'(WORD_BITS - 1)) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = ST_XFER;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready_o = (ctl_q.state == ST_IDLE);
    assign rdata_o = ctl_q.rdata;
    assign done_o  = ctl_q.done;
endmodule

// File: rtl/delay_line_mem_chk.sv
module delay_line_mem_chk #(
    parameter int WORDS_PER_LINE = 16,
    parameter int WORD_BITS      = 35,
    localparam int SLOT_W    = $clog2(WORDS_PER_LINE),
    localparam int BIT_W     = $clog2(WORD_BITS),
    localparam int MAX_BUSY  = WORDS_PER_LINE * WORD_BITS + WORD_BITS,
    localparam int CNT_W     = $clog2(MAX_BUSY + 2) + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_i,
    input logic                 ready_o,
    input logic                 done_o,
    input logic [WORD_BITS-1:0] rdata_o,
    input logic [SLOT_W-1:0]    word_pos,
    input logic [BIT_W-1:0]     bit_pos
);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         busy_cnt <= '0;
        else if (ready_o)                   busy_cnt <= '0;
        else if (busy_cnt != {CNT_W{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> !ready_o); // R2

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bit_pos) == BIT_W'(WORD_BITS - 1))); // R7

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos != BIT_W'(WORD_BITS - 1)) |=> (bit_pos == BIT_W'($past(bit_pos) + 1'b1))); // R7

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos == BIT_W'(WORD_BITS - 1) && word_pos == SLOT_W'(WORDS_PER_LINE - 1))
        |=> (bit_pos == '0 && word_pos == '0)); // R7

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(MAX_BUSY)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> $stable(rdata_o)); // R9
endmodule

bind delay_line_mem delay_line_mem_chk #(
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .WORD_BITS      (WORD_BITS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .rdata_o  (rdata_o),
    .word_pos (word_pos),
    .bit_pos  (bit_pos)
);

// File: tb/delay_line_mem_tb_top.sv
module delay_line_mem_tb_top;
    localparam int NL = 32;
    localparam int WPL = 16;
    localparam int WB = 35;
    localparam int LB = WPL * WB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [4:0]    line_i = '0;
    logic [3:0]    slot_i = '0;
    logic          we_i = 1'b0;
    logic [WB-1:0] wdata_i = '0;
    logic          ready_o;
    logic [WB-1:0] rdata_o;
    logic          done_o;

    always #4 clk = ~clk;

    delay_line_mem dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_o(ready_o),
        .line_i(line_i), .slot_i(slot_i), .we_i(we_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .done_o(done_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R3";

    // behavioural reference
    logic [WB-1:0] m_mem [NL][WPL];
    int            m_pos = 0;
    bit            m_busy = 0;
    bit            m_wait = 0;
    bit            m_done = 0;
    bit            m_lastwe = 0;
    int            m_line = 0;
    int            m_slot = 0;
    bit            m_we = 0;
    logic [WB-1:0] m_wd = '0;
    logic [WB-1:0] m_rdata = '0;

    initial begin
        for (int i = 0; i < NL; i++)
            for (int j = 0; j < WPL; j++) m_mem[i][j] = '0;
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (cycles > 1) begin
            chk(rst_n ? "R2" : "R1", "ready", ready_o, !m_busy);
            chk(rst_n ? "R7" : "R1", "done", done_o, m_done);
            if (!m_busy) begin
                if (m_done && !m_lastwe) chk(cur_tag, "read data", rdata_o, m_rdata);
                else chk(rst_n ? "R9" : "R1", "rdata hold", rdata_o, m_rdata);
            end
            if (rst_n) begin
                m_done = 0;
                if (m_busy) begin
                    if (m_wait && m_pos == m_slot * WB) m_wait = 0;
                    if (!m_wait && m_pos == m_slot * WB + WB - 1) begin
                        m_busy = 0;
                        m_done = 1;
                        m_lastwe = m_we;
                        if (m_we) m_mem[m_line][m_slot] = m_wd;
                        else m_rdata = m_mem[m_line][m_slot];
                    end
                end else if (req_i) begin
                    m_busy = 1;
                    m_wait = 1;
                    m_line = int'(line_i);
                    m_slot = int'(slot_i);
                    m_we = we_i;
                    m_wd = wdata_i;
                end
                m_pos = (m_pos + 1) % LB;
            end
        end
    end

    task automatic access(input int l, input int s, input bit w, input logic [WB-1:0] d,
                          input bit junk, input string tag, output logic [WB-1:0] rd);
        @(posedge clk); #1;
        while (!ready_o) begin @(posedge clk); #1; end
        cur_tag = tag;
        req_i = 1'b1; line_i = 5'(l); slot_i = 4'(s); we_i = w; wdata_i = d;
        @(posedge clk); #1;
        req_i = 1'b0;
        if (junk) begin
            // R10: requests while busy, aimed at line 3 slot 5 with zero data
            req_i = 1'b1; line_i = 5'd3; slot_i = 4'd5; we_i = 1'b1; wdata_i = '0;
            repeat (6) begin @(posedge clk); #1; end
            req_i = 1'b0;
        end
        while (!done_o) begin @(posedge clk); #1; end
        rd = rdata_o;
        chk("R8", "ready with done", ready_o, 1'b1);
        @(posedge clk); #1;
        chk("R8", "done pulse width", done_o, 1'b0);
    endtask

    task automatic wr(input int l, input int s, input logic [WB-1:0] d, input bit junk);
        logic [WB-1:0] unused_rd;
        access(l, s, 1'b1, d, junk, "R3", unused_rd);
    endtask

    task automatic rd_expect(input int l, input int s, input logic [WB-1:0] exp,
                             input bit junk, input string tag);
        logic [WB-1:0] got;
        access(l, s, 1'b0, '0, junk, tag, got);
        chk(tag, "read value", got, exp);
    endtask

    initial begin
        logic [WB-1:0] held;
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "reset ready", ready_o, 1'b1);
        chk("R1", "reset done", done_o, 1'b0);
        chk("R1", "reset rdata", rdata_o, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        rd_expect(0, 0, '0, 0, "R1");
        rd_expect(31, 15, '0, 0, "R1");

        wr(3, 5, 35'h5_5555_5555, 0);
        rd_expect(3, 5, 35'h5_5555_5555, 0, "R3");
        wr(3, 6, 35'h7_FFFF_FFFF, 0);
        rd_expect(3, 5, 35'h5_5555_5555, 0, "R4");
        rd_expect(3, 6, 35'h7_FFFF_FFFF, 0, "R3");
        rd_expect(4, 5, '0, 0, "R4");
        rd_expect(3, 4, '0, 0, "R4");
        rd_expect(3, 7, '0, 0, "R4");

        wr(31, 15, 35'h4_0000_0001, 0);
        wr(0, 0, 35'h1_2345_6789, 0);
        rd_expect(31, 15, 35'h4_0000_0001, 0, "R3");
        rd_expect(0, 0, 35'h1_2345_6789, 0, "R3");

        rd_expect(3, 6, 35'h7_FFFF_FFFF, 0, "R5");
        rd_expect(3, 6, 35'h7_FFFF_FFFF, 0, "R5");

        repeat (1500) @(posedge clk);
        #1;
        rd_expect(3, 5, 35'h5_5555_5555, 0, "R6");
        rd_expect(31, 15, 35'h4_0000_0001, 0, "R6");

        wr(10, 2, 35'h2_AAAA_0F0F, 1);
        rd_expect(3, 5, 35'h5_5555_5555, 0, "R10");
        rd_expect(10, 2, 35'h2_AAAA_0F0F, 0, "R3");
        rd_expect(0, 0, 35'h1_2345_6789, 1, "R10");
        rd_expect(3, 5, 35'h5_5555_5555, 0, "R10");

        held = rdata_o;
        repeat (50) @(posedge clk);
        #1;
        chk("R9", "rdata idle hold", rdata_o, held);
        wr(7, 9, 35'h0_DEAD_BEEF, 0);
        chk("R9", "rdata after write", rdata_o, held);

        wr(3, 5, '0, 0);
        rd_expect(3, 5, '0, 0, "R3");
        rd_expect(7, 9, 35'h0_DEAD_BEEF, 0, "R3");
        rd_expect(3, 6, 35'h7_FFFF_FFFF, 0, "R4");

        repeat (3) @(posedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule